// File: doc/BRIEF.md
# Frame-Based Hard-Decision Viterbi Decoder

This block turns a frame of rate-1/2 convolutionally coded symbols back into the data bits that produced them. Each symbol is a pair of hard-decision bits. For every symbol the decoder forms the Hamming distance to each of the four possible code pairs. It then updates a path metric for each of the 64 trellis states of a constraint-length-7 code, and keeps one decision bit per state in a survivor store.

The frame is closed by a symbol marked with `frame_last`. The decoder then raises `busy` and walks the stored decisions backwards, one stage per clock, starting from state 0 at the final stage. The recovered bits come out in reverse time order, so they go into a reversal buffer. The decoder then plays them out in transmit order, one bit per clock, marked by `out_valid`, with `out_last` on the final bit. The output includes the six tail bits. Input is ignored until the output is complete and `busy` has dropped.

Top module: `viterbi_frame_dec`

## Requirements
- R1: Code definition. `in_sym[1]` is the parity of the taps given by octal 171, and `in_sym[0]` is the parity of the taps given by octal 133. In both masks bit 6 selects the current data bit and bits 5..0 select the six previous bits, newest first. The encoder starts in state 0 and each frame ends with six zero tail bits. For an error-free frame, every output bit equals the transmitted bit.
- R2: The branch metric is the Hamming distance between the received pair and the expected pair. A frame in which no two channel bit flips lie in the same 14-symbol block is decoded without error.
- R3: Path metrics are 8 bits wide and are compared by modulo subtraction. On the first symbol of a frame, state 0 starts at metric 0 and every other state starts at 64, so no frame is affected by the one before it.
- R4: For each state, the decoder adds the branch metrics to the two predecessor metrics, keeps the smaller sum, and stores which predecessor won. On a tie the predecessor whose oldest bit is 0 is kept.
- R5: Traceback begins only after the `frame_last` symbol has been accepted. It starts from state 0 at the final stage and ends at state 0 at the first stage.
- R6: The decoder emits one `out_bit` per `out_valid` cycle, in transmit order. The number of bits emitted equals the number of symbols in the frame, tail bits included.
- R7: `out_last` is high on the final output bit of a frame and on no other bit.
- R8: `busy` is high from the cycle after the `frame_last` symbol is accepted until the last output bit. Symbols presented while `busy` is high have no effect on the current output or on the next frame.
- R9: Frames of 7 to 256 symbols are decoded.
- R10: After reset, `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A symbol is presented |
| in_sym | input | 2 | Hard-decision pair: bit 1 is the 171 output, bit 0 is the 133 output |
| frame_last | input | 1 | Marks the final symbol of the frame |
| busy | output | 1 | Traceback or output in progress; input is ignored |
| out_valid | output | 1 | `out_bit` carries a decoded bit |
| out_bit | output | 1 | Decoded data bit |
| out_last | output | 1 | Final decoded bit of the frame |

## Verification
The assertions assume that every frame is encoded from state 0, ends with six zero tail bits, and is no longer than 256 symbols. Under that assumption the path that traceback follows must end in state 0 at the first stage, and the state-0 metric after the first symbol can be at most 2. The stimulus keeps to this. The bench encodes each frame with its own reference encoder and appends the tail. It draws frame lengths from 7 to 256 symbols and flips at most one channel bit in each 14-symbol block, so every frame stays inside the error pattern the code is guaranteed to correct. It also presents symbols while `busy` is high to show that they are dropped.

// File: rtl/vdec_pkg.sv
package vdec_pkg;
    localparam int CL      = 7;
    localparam int SW      = CL - 1;
    localparam int NS      = 1 << SW;
    localparam int PMW     = 8;
    localparam int MAXST   = 256;
    localparam int SIW     = $clog2(MAXST);
    localparam logic [CL-1:0] TAP_HI = 7'o171;
    localparam logic [CL-1:0] TAP_LO = 7'o133;
    localparam logic [PMW-1:0] PM_FAR = 8'd64;

    typedef logic [SW-1:0]  state_t;
    typedef logic [PMW-1:0] pm_t;
    typedef logic [1:0]     sym_t;
    typedef logic [NS-1:0]  dec_t;
    typedef logic [SIW-1:0] stage_t;
    typedef logic [3:0][1:0] bm_vec_t;

    typedef enum logic [1:0] {PH_FILL, PH_TRACE, PH_EMIT} phase_t;

    function automatic sym_t branch_out(state_t s, logic u);
        logic [CL-1:0] r;
        r = {u, s};
        return {^(r & TAP_HI), ^(r & TAP_LO)};
    endfunction

    function automatic logic [1:0] hdist(sym_t a, sym_t b);
        sym_t x;
        x = a ^ b;
        return {x[1] & x[0], x[1] ^ x[0]};
    endfunction

    function automatic logic pm_less(pm_t a, pm_t b);
        pm_t d;
        d = a - b;
        return d[PMW-1];
    endfunction
endpackage

// File: rtl/vdec_bmu.sv
module vdec_bmu
    import vdec_pkg::*;
(
    input  sym_t    sym,
    output bm_vec_t bm
);
    for (genvar c = 0; c < 4; c++) begin : g_code
        assign bm[c] = hdist(sym, sym_t'(c));
    end
endmodule

// File: rtl/vdec_acs.sv
module vdec_acs
    import vdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  logic    fresh,
    input  bm_vec_t bm,
    output dec_t    dec
);
    pm_t pm   [NS];
    pm_t base [NS];
    pm_t nxt  [NS];

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            if (fresh) base[i] = (i == 0) ? '0 : PM_FAR;
            else       base[i] = pm[i];
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_st
        localparam int   P0 = (s * 2) % NS;
        localparam int   P1 = P0 + 1;
        localparam logic U  = (s >> (SW - 1)) == 1;
        localparam sym_t C0 = branch_out(state_t'(P0), U);
        localparam sym_t C1 = branch_out(state_t'(P1), U);
        pm_t  m0, m1;
        logic sel;
        always_comb begin
            m0  = base[P0] + pm_t'(bm[C0]);
            m1  = base[P1] + pm_t'(bm[C1]);
            sel = pm_less(m1, m0);
            nxt[s] = sel ? m1 : m0;
        end
        assign dec[s] = sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : PM_FAR;
        end else if (step) begin
            for (int i = 0; i < NS; i++) pm[i] <= nxt[i];
        end
    end

    // R3: after the first symbol of a frame, state 0 holds at most one branch metric
    a_r3_fresh_start: assert property (@(posedge clk) disable iff (rst)
        step && fresh |=> (pm[0] <= pm_t'(2)));
endmodule

// File: rtl/vdec_surv.sv
module vdec_surv
    import vdec_pkg::*;
(
    input  logic   clk,
    input  logic   we,
    input  stage_t waddr,
    input  dec_t   wdata,
    input  stage_t raddr,
    output dec_t   rdata
);
    dec_t mem [MAXST];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vdec_ctrl.sv
module vdec_ctrl
    import vdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   frame_last,
    input  dec_t   rd_dec,
    output logic   step,
    output logic   fresh,
    output stage_t waddr,
    output stage_t raddr,
    output logic   busy,
    output logic   out_valid,
    output logic   out_bit,
    output logic   out_last
);
    phase_t       phase;
    stage_t       wr_idx, last_idx, tb_idx, out_idx;
    state_t       tb_st;
    logic [MAXST-1:0] rev;

    assign step      = in_valid && (phase == PH_FILL);
    assign fresh     = (wr_idx == '0);
    assign waddr     = wr_idx;
    assign raddr     = tb_idx;
    assign busy      = (phase != PH_FILL);
    assign out_valid = (phase == PH_EMIT);
    assign out_bit   = rev[out_idx];
    assign out_last  = (phase == PH_EMIT) && (out_idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_FILL;
            wr_idx   <= '0;
            last_idx <= '0;
            tb_idx   <= '0;
            out_idx  <= '0;
            tb_st    <= '0;
        end else begin
            unique case (phase)
                PH_FILL: if (step) begin
                    if (frame_last) begin
                        last_idx <= wr_idx;
                        tb_idx   <= wr_idx;
                        tb_st    <= '0;
                        wr_idx   <= '0;
                        phase    <= PH_TRACE;
                    end else begin
                        wr_idx <= wr_idx + 1'b1;
                    end
                end
                PH_TRACE: begin
                    tb_st <= {tb_st[SW-2:0], rd_dec[tb_st]};
                    if (tb_idx == '0) begin
                        out_idx <= '0;
                        phase   <= PH_EMIT;
                    end else begin
                        tb_idx <= tb_idx - 1'b1;
                    end
                end
                PH_EMIT: begin
                    if (out_idx == last_idx) phase <= PH_FILL;
                    else                     out_idx <= out_idx + 1'b1;
                end
                default: phase <= PH_FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (phase == PH_TRACE) rev[tb_idx] <= tb_st[SW-1];
    end

    // R5: the surviving path ends in the start state at the first stage
    a_r5_trace_home: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRACE) && (tb_idx == '0) |=> (tb_st == '0));
    // R9: a frame never runs past the survivor store
    a_r9_frame_fits: assert property (@(posedge clk) disable iff (rst)
        step && (wr_idx == stage_t'(MAXST - 1)) |-> frame_last);
    // R8: output only while busy, and busy right after the closing symbol
    a_r8_busy_output: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);
    a_r8_busy_rise: assert property (@(posedge clk) disable iff (rst)
        step && frame_last |=> busy);
    // R7: out_last ends the emission
    a_r7_last_ends: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_valid);
    a_r7_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

// File: rtl/viterbi_frame_dec.sv
module viterbi_frame_dec
    import vdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] in_sym,
    input  logic       frame_last,
    output logic       busy,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last
);
    bm_vec_t bm;
    dec_t    dec_new, dec_rd;
    logic    step, fresh;
    stage_t  waddr, raddr;

    vdec_bmu u_bmu (.sym(in_sym), .bm(bm));

    vdec_acs u_acs (
        .clk(clk), .rst(rst), .step(step), .fresh(fresh),
        .bm(bm), .dec(dec_new)
    );

    vdec_surv u_surv (
        .clk(clk), .we(step), .waddr(waddr), .wdata(dec_new),
        .raddr(raddr), .rdata(dec_rd)
    );

    vdec_ctrl u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frame_last(frame_last),
        .rd_dec(dec_rd), .step(step), .fresh(fresh), .waddr(waddr),
        .raddr(raddr), .busy(busy), .out_valid(out_valid),
        .out_bit(out_bit), .out_last(out_last)
    );
endmodule

// File: tb/viterbi_frame_dec_tb_top.sv
module viterbi_frame_dec_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [1:0] in_sym;
    logic       frame_last;
    logic       busy, out_valid, out_bit, out_last;

    always #2 clk = ~clk;

    viterbi_frame_dec dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
        .frame_last(frame_last), .busy(busy), .out_valid(out_valid),
        .out_bit(out_bit), .out_last(out_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit [1:0] exp_q[$];

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference encoder: taps 171/133 octal, bit 6 = current bit
    function automatic logic [1:0] ref_enc(logic [5:0] hist, logic b);
        logic [6:0] w;
        w = {b, hist};
        return {^(w & 7'b1111001), ^(w & 7'b1011011)};
    endfunction

    // mode: 0 clean random, 1 noisy random, 2 clean all ones, 3 noisy + input while busy
    task automatic run_frame(int ndata, int mode, string req);
        logic bits[$];
        logic [1:0] syms[$];
        logic [5:0] hist = '0;
        int n;
        for (int i = 0; i < ndata; i++)
            bits.push_back(mode == 2 ? 1'b1 : 1'($urandom_range(0, 1)));
        for (int i = 0; i < 6; i++) bits.push_back(1'b0);
        n = bits.size();
        foreach (bits[i]) begin
            syms.push_back(ref_enc(hist, bits[i]));
            hist = {bits[i], hist[5:1]};
        end
        if (mode == 1 || mode == 3) begin
            for (int j = 0; j < n; j += 14) begin
                int p = j + $urandom_range(0, 13);
                if (p < n) syms[p][$urandom_range(0, 1)] ^= 1'b1;
            end
        end
        foreach (bits[i]) exp_q.push_back({bits[i], 1'(i == n - 1)});
        while (busy) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            in_valid   = 1'b1;
            in_sym     = syms[i];
            frame_last = (i == n - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        frame_last = 1'b0;
        chk(busy == 1'b1, "R8 busy after closing symbol", int'(busy), 1);
        while (busy) begin
            if (mode == 3) begin
                in_valid   = 1'b1;
                in_sym     = 2'($urandom_range(0, 3));
                frame_last = 1'($urandom_range(0, 1));
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        frame_last = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, {"R6 all bits emitted ", req}, exp_q.size(), 0);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected output bit", 1, 0);
            end else begin
                bit [1:0] e;
                e = exp_q.pop_front();
                chk(out_bit == e[1], "R1/R2 decoded bit", int'(out_bit), int'(e[1]));
                chk(out_last == e[0], "R7 out_last flag", int'(out_last), int'(e[0]));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_sym = '0;
        frame_last = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
        chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);

        run_frame(40, 0, "R1 clean frame");
        run_frame(1, 0, "R9 shortest frame");
        run_frame(250, 1, "R9 longest frame noisy");
        run_frame(64, 2, "R4 all ones");
        for (int k = 0; k < 6; k++) run_frame(20 + 17 * k, 1, "R2 noisy frame");
        run_frame(50, 3, "R8 input while busy");
        run_frame(30, 0, "R3 frame after ignored input");
        run_frame(100, 1, "R5 noisy frame");

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R6 idle after frames", int'(out_valid), 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule